// File: doc/BRIEF.md
# Tape Controller Command and Status Unit

This block is the command channel of a nine-track tape controller. The host writes an 8-bit function code. The block checks that code against the current state of the drive and the controller. It then either starts the operation or marks the attempt as a reject. It holds a 9-bit status word that the host can refresh and read. When an operation completes, it raises a command-channel completion flag.

The block does no record formatting and moves no bytes. A separate data engine does that work. When an operation has been accepted and a programmable start latency has elapsed, the engine receives a one-cycle start pulse carrying the function. That pulse also tells the engine to reset its buffer pointer and arm its first-service and transfer state. The engine answers with a done pulse and a set of condition bits. The block turns those into status and the completion flag.

Top module: `tape_cmd_unit`

## Requirements
- R1: After reset with a drive attached, status reads BOT (octal 100) when `tapeAtStart` is high, plus write-locked (octal 004) when `writeProtect` is high. With no drive attached it reads local plus busy (octal 401). `cmdFlag` is low after reset.
- R2: A valid function code is accepted when no rejecting condition holds. The valid codes, in octal, are write 031, read 023, gap 011, forward space 003, backward space 041, rewind 201, rewind-offline 101 and file mark 035. On acceptance:
  - status becomes exactly busy (octal 001);
  - `cmdFlag` clears;
  - `dataChanClr` pulses in the strobe cycle;
  - `engStart` pulses for one cycle, on the START_DELAY-th cycle after the accepting edge, with `engFunc` equal to the code.
- R3: A code that is neither a valid code nor clear (octal 300) ORs the reject bit (octal 010) into status. It starts nothing, and it leaves all other status bits and `cmdFlag` unchanged.
- R4: A valid code is rejected in the same way when an operation is active (from acceptance until engine done or abort) or when no drive is attached.
- R5: A valid code is rejected when status has BOT set and the code is backward space, rewind or rewind-offline.
- R6: A valid code is rejected when `writeProtect` is high and the code is write, gap or file mark.
- R7: Clear (octal 300) ends any activity. It pulses `engAbort` and `dataChanClr`, lowers `cmdFlag`, and loads status with the reset value of R1. While a rewind or rewind-offline is active, clear is ignored: there are no pulses and no change.
- R8: A status read strobe refreshes status. With a drive attached, local is cleared, write-locked follows `writeProtect`, busy follows the active state, and the other bits keep their values. With no drive attached, status becomes exactly octal 401.
- R9: Engine done for a rewind sets BOT, clears busy and raises `cmdFlag`.
- R10: Engine done for a rewind-offline loads status with octal 401, leaves `cmdFlag` low and pulses `goOffline` in the done cycle.
- R11: Engine done for a file mark sets EOF (octal 200), clears busy and raises `cmdFlag`.
- R12: Engine done for write, read, gap or either space ORs in the `engResult` bits under mask octal 362 (EOF, BOT, EOT, timing, parity), clears busy and raises `cmdFlag`.
- R13: `hostFlagClr` lowers `cmdFlag` one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hostWrStb | input | 1 | Host function-code write strobe |
| hostWrData | input | 8 | Function code |
| statRdStb | input | 1 | Host status read (refresh) strobe |
| hostFlagClr | input | 1 | Host clears the completion flag |
| driveAttached | input | 1 | A drive is online |
| writeProtect | input | 1 | Mounted reel is write protected |
| tapeAtStart | input | 1 | Tape position is zero (used at reset and clear) |
| engDone | input | 1 | Data engine finished the operation |
| engResult | input | 9 | Engine condition bits, status bit positions |
| statusWord | output | 9 | Status register |
| cmdFlag | output | 1 | Command-channel completion flag |
| engStart | output | 1 | One-cycle start to the data engine |
| engFunc | output | 8 | Function being executed |
| engAbort | output | 1 | One-cycle abort to the engine on clear |
| dataChanClr | output | 1 | Clear the data channel's flag (accept or clear) |
| goOffline | output | 1 | Take the drive offline after rewind-offline |

## Verification
The bench builds the block with START_DELAY set to 4. At that value the exact start cycle can be counted on every accepted command, and a host write can be issued inside both the waiting and the running window. These writes reach the busy-reject path and the clear-during-rewind exemption many times within the run. A short delay also lets the random loop cycle through dozens of complete operations, including rewind-offline detach and reattach sequences.

// File: rtl/tape_cmd_pkg.sv
package tape_cmd_pkg;

  localparam logic [7:0] FN_CLEAR   = 8'o300;
  localparam logic [7:0] FN_WRITE   = 8'o031;
  localparam logic [7:0] FN_READ    = 8'o023;
  localparam logic [7:0] FN_GAP     = 8'o011;
  localparam logic [7:0] FN_FWDSP   = 8'o003;
  localparam logic [7:0] FN_BACKSP  = 8'o041;
  localparam logic [7:0] FN_REWIND  = 8'o201;
  localparam logic [7:0] FN_REWOFF  = 8'o101;
  localparam logic [7:0] FN_FMARK   = 8'o035;

  localparam int NUM_FUNCS = 8;
  localparam logic [7:0] FUNC_TABLE [NUM_FUNCS] = '{
    FN_WRITE, FN_READ, FN_GAP, FN_FWDSP, FN_BACKSP, FN_REWIND, FN_REWOFF, FN_FMARK
  };

  localparam logic [8:0] ST_LOCAL  = 9'o400;
  localparam logic [8:0] ST_EOF    = 9'o200;
  localparam logic [8:0] ST_BOT    = 9'o100;
  localparam logic [8:0] ST_EOT    = 9'o040;
  localparam logic [8:0] ST_TIMING = 9'o020;
  localparam logic [8:0] ST_REJECT = 9'o010;
  localparam logic [8:0] ST_WLOCK  = 9'o004;
  localparam logic [8:0] ST_PARITY = 9'o002;
  localparam logic [8:0] ST_BUSY   = 9'o001;
  localparam logic [8:0] ST_ENG_MASK = ST_EOF | ST_BOT | ST_EOT | ST_TIMING | ST_PARITY;

  typedef struct packed {
    logic accept;
    logic reject;
    logic clear;
    logic refresh;
    logic doneRew;
    logic doneRwOff;
    logic doneFmark;
    logic doneOther;
  } ctrlStrb_t;

  function automatic logic fnKnown(input logic [7:0] code);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < NUM_FUNCS; i++) begin
      if (code == FUNC_TABLE[i]) hit = 1'b1;
    end
    return hit;
  endfunction

  function automatic logic fnIsRewind(input logic [7:0] code);
    return (code == FN_REWIND) || (code == FN_REWOFF);
  endfunction

  function automatic logic fnMovesBack(input logic [7:0] code);
    return (code == FN_BACKSP) || fnIsRewind(code);
  endfunction

  function automatic logic fnWrites(input logic [7:0] code);
    return (code == FN_WRITE) || (code == FN_GAP) || (code == FN_FMARK);
  endfunction

endpackage

// File: rtl/tape_cmd_ctrl.sv
module tape_cmd_ctrl
  import tape_cmd_pkg::*;
#(
  parameter int START_DELAY = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hostWrStb,
  input  logic [7:0] hostWrData,
  input  logic       statRdStb,
  input  logic       driveAttached,
  input  logic       writeProtect,
  input  logic       botSet,
  input  logic       engDone,
  output ctrlStrb_t  strb,
  output logic       active,
  output logic       engStart,
  output logic [7:0] engFunc,
  output logic       engAbort,
  output logic       dataChanClr,
  output logic       goOffline
);

  localparam int CW = (START_DELAY < 2) ? 1 : $clog2(START_DELAY + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(START_DELAY - 1);

  typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_RUN} phase_t;

  phase_t      phase;
  logic [CW-1:0] cnt;
  logic [7:0]  funcQ;
  logic        isClr, badCode, rewindBusy, runDone;

  assign active = (phase != PH_IDLE);

  always_comb begin
    isClr      = (hostWrData == FN_CLEAR);
    rewindBusy = active && fnIsRewind(funcQ);
    badCode    = !fnKnown(hostWrData) || active || !driveAttached ||
                 (botSet && fnMovesBack(hostWrData)) ||
                 (writeProtect && fnWrites(hostWrData));
    runDone    = (phase == PH_RUN) && engDone;

    strb           = '0;
    strb.clear     = hostWrStb && isClr && !rewindBusy;
    strb.accept    = hostWrStb && !isClr && !badCode;
    strb.reject    = hostWrStb && !isClr && badCode;
    strb.refresh   = statRdStb;
    strb.doneRew   = runDone && (funcQ == FN_REWIND);
    strb.doneRwOff = runDone && (funcQ == FN_REWOFF);
    strb.doneFmark = runDone && (funcQ == FN_FMARK);
    strb.doneOther = runDone && !fnIsRewind(funcQ) && (funcQ != FN_FMARK);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      funcQ <= '0;
    end else if (strb.clear) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      funcQ <= '0;
    end else if (strb.accept) begin
      phase <= PH_WAIT;
      cnt   <= CNT_LOAD;
      funcQ <= hostWrData;
    end else begin
      case (phase)
        PH_WAIT: begin
          if (cnt == '0) phase <= PH_RUN;
          else           cnt   <= cnt - 1'b1;
        end
        PH_RUN:  if (engDone) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign engStart    = (phase == PH_WAIT) && (cnt == '0);
  assign engFunc     = funcQ;
  assign engAbort    = strb.clear;
  assign dataChanClr = strb.accept || strb.clear;
  assign goOffline   = strb.doneRwOff;

  // R2: the start pulse lasts one cycle
  a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    engStart |=> !engStart);

  // R3: a reject from idle never starts an operation
  a_r3_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.reject && !active) |=> !active);

  // R7: clear always leaves the controller idle
  a_r7_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clear |=> !active);

  // R2: accept never coincides with clear or reject
  a_r2_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({strb.accept, strb.reject, strb.clear}) <= 1);

endmodule

// File: rtl/tape_cmd_status.sv
module tape_cmd_status
  import tape_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ctrlStrb_t  strb,
  input  logic       active,
  input  logic       driveAttached,
  input  logic       writeProtect,
  input  logic       tapeAtStart,
  input  logic       hostFlagClr,
  input  logic [8:0] engResult,
  output logic [8:0] statusWord,
  output logic       cmdFlag,
  output logic       botSet
);

  logic [8:0] initVal, nxtStatus;
  logic       nxtFlag, raiseFlag;

  always_comb begin
    if (driveAttached)
      initVal = (tapeAtStart ? ST_BOT : 9'd0) | (writeProtect ? ST_WLOCK : 9'd0);
    else
      initVal = ST_LOCAL | ST_BUSY;
  end

  always_comb begin
    nxtStatus = statusWord;
    nxtFlag   = cmdFlag;
    raiseFlag = strb.doneRew || strb.doneFmark || strb.doneOther;
    if (strb.clear) begin
      nxtStatus = initVal;
      nxtFlag   = 1'b0;
    end else if (strb.accept) begin
      nxtStatus = ST_BUSY;
      nxtFlag   = 1'b0;
    end else begin
      if (strb.doneRew)   nxtStatus = (nxtStatus | ST_BOT) & ~ST_BUSY;
      if (strb.doneRwOff) nxtStatus = ST_LOCAL | ST_BUSY;
      if (strb.doneFmark) nxtStatus = (nxtStatus | ST_EOF) & ~ST_BUSY;
      if (strb.doneOther) nxtStatus = (nxtStatus | (engResult & ST_ENG_MASK)) & ~ST_BUSY;
      if (strb.reject)    nxtStatus = nxtStatus | ST_REJECT;
      if (strb.refresh) begin
        if (driveAttached)
          nxtStatus = (nxtStatus & ~(ST_LOCAL | ST_WLOCK | ST_BUSY)) |
                      (active ? ST_BUSY : 9'd0) | (writeProtect ? ST_WLOCK : 9'd0);
        else
          nxtStatus = ST_LOCAL | ST_BUSY;
      end
      if (raiseFlag)        nxtFlag = 1'b1;
      else if (hostFlagClr) nxtFlag = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      statusWord <= initVal;
      cmdFlag    <= 1'b0;
    end else begin
      statusWord <= nxtStatus;
      cmdFlag    <= nxtFlag;
    end
  end

  assign botSet = (statusWord & ST_BOT) != 9'd0;

  // R2: acceptance leaves busy alone in status and the flag low
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    strb.accept |=> (statusWord == ST_BUSY) && !cmdFlag);

  // R3: a reject sets the reject bit
  a_r3_reject_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.reject && !strb.refresh) |=> statusWord[3]);

  // R9: rewind completion
  a_r9_rewind_done: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.doneRew && !strb.clear && !strb.refresh) |=> statusWord[6] && !statusWord[0] && cmdFlag);

  // R10: rewind-offline completion leaves local+busy and no flag
  a_r10_rwoff_done: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.doneRwOff && !strb.clear && !strb.reject) |=> (statusWord == (ST_LOCAL | ST_BUSY)) && (cmdFlag == $past(cmdFlag)));

  // R11: file mark completion
  a_r11_fmark_done: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.doneFmark && !strb.clear && !strb.refresh) |=> statusWord[7] && !statusWord[0] && cmdFlag);

  // R8: a read with no drive yields local plus busy
  a_r8_detached_read: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.refresh && !driveAttached && !strb.clear) |=> statusWord == (ST_LOCAL | ST_BUSY));

  // R13: host flag clear takes effect when no completion competes
  a_r13_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (hostFlagClr && !strb.doneRew && !strb.doneFmark && !strb.doneOther) |=> !cmdFlag);

endmodule

// File: rtl/tape_cmd_unit.sv
module tape_cmd_unit
  import tape_cmd_pkg::*;
#(
  parameter int START_DELAY = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hostWrStb,
  input  logic [7:0] hostWrData,
  input  logic       statRdStb,
  input  logic       hostFlagClr,
  input  logic       driveAttached,
  input  logic       writeProtect,
  input  logic       tapeAtStart,
  input  logic       engDone,
  input  logic [8:0] engResult,
  output logic [8:0] statusWord,
  output logic       cmdFlag,
  output logic       engStart,
  output logic [7:0] engFunc,
  output logic       engAbort,
  output logic       dataChanClr,
  output logic       goOffline
);

  ctrlStrb_t strb;
  logic      active;
  logic      botSet;

  tape_cmd_ctrl #(.START_DELAY(START_DELAY)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .hostWrStb    (hostWrStb),
    .hostWrData   (hostWrData),
    .statRdStb    (statRdStb),
    .driveAttached(driveAttached),
    .writeProtect (writeProtect),
    .botSet       (botSet),
    .engDone      (engDone),
    .strb         (strb),
    .active       (active),
    .engStart     (engStart),
    .engFunc      (engFunc),
    .engAbort     (engAbort),
    .dataChanClr  (dataChanClr),
    .goOffline    (goOffline)
  );

  tape_cmd_status u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .strb         (strb),
    .active       (active),
    .driveAttached(driveAttached),
    .writeProtect (writeProtect),
    .tapeAtStart  (tapeAtStart),
    .hostFlagClr  (hostFlagClr),
    .engResult    (engResult),
    .statusWord   (statusWord),
    .cmdFlag      (cmdFlag),
    .botSet       (botSet)
  );

  initial begin
    if (START_DELAY < 1) $error("START_DELAY must be at least 1");
  end

endmodule

// File: tb/tape_cmd_unit_test.sv
module tape_cmd_unit_test;

  localparam int D = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hostWrStb = 1'b0;
  logic [7:0] hostWrData = 8'd0;
  logic       statRdStb = 1'b0;
  logic       hostFlagClr = 1'b0;
  logic       driveAttached = 1'b1;
  logic       writeProtect = 1'b0;
  logic       tapeAtStart = 1'b1;
  logic       engDone = 1'b0;
  logic [8:0] engResult = 9'd0;
  logic [8:0] statusWord;
  logic       cmdFlag, engStart, engAbort, dataChanClr, goOffline;
  logic [7:0] engFunc;

  tape_cmd_unit #(.START_DELAY(D)) uut (
    .clk(clk), .rst_n(rst_n), .hostWrStb(hostWrStb), .hostWrData(hostWrData),
    .statRdStb(statRdStb), .hostFlagClr(hostFlagClr), .driveAttached(driveAttached),
    .writeProtect(writeProtect), .tapeAtStart(tapeAtStart), .engDone(engDone),
    .engResult(engResult), .statusWord(statusWord), .cmdFlag(cmdFlag),
    .engStart(engStart), .engFunc(engFunc), .engAbort(engAbort),
    .dataChanClr(dataChanClr), .goOffline(goOffline)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // reference model state
  logic [8:0] mSt;
  logic       mFlag, mActive;
  logic [7:0] mFunc;

  function automatic logic known(input logic [7:0] c);
    return c == 8'o031 || c == 8'o023 || c == 8'o011 || c == 8'o003 ||
           c == 8'o041 || c == 8'o201 || c == 8'o101 || c == 8'o035;
  endfunction
  function automatic logic isRew(input logic [7:0] c);
    return c == 8'o201 || c == 8'o101;
  endfunction
  function automatic logic [8:0] initStatus();
    if (!driveAttached) return 9'o401;
    return (tapeAtStart ? 9'o100 : 9'o000) | (writeProtect ? 9'o004 : 9'o000);
  endfunction
  function automatic logic rejects(input logic [7:0] c);
    return !known(c) || mActive || !driveAttached ||
           (mSt[6] && (c == 8'o041 || isRew(c))) ||
           (writeProtect && (c == 8'o031 || c == 8'o011 || c == 8'o035));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%o expected=%o", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    mSt = initStatus(); mFlag = 1'b0; mActive = 1'b0; mFunc = 8'd0;
    check("R1 reset status", statusWord, mSt);
    check("R1 reset flag", cmdFlag, 1'b0);
  endtask

  // returns 1 when the write was accepted
  task automatic hostWrite(input logic [7:0] c, output logic acc);
    logic clrEff, expPulse;
    @(negedge clk);
    hostWrStb = 1'b1; hostWrData = c;
    acc = 1'b0;
    clrEff = (c == 8'o300) && !(mActive && isRew(mFunc));
    if (c == 8'o300) begin
      if (clrEff) begin
        mSt = initStatus(); mFlag = 1'b0; mActive = 1'b0; mFunc = 8'd0;
      end
    end else if (rejects(c)) begin
      mSt = mSt | 9'o010;
    end else begin
      mSt = 9'o001; mFlag = 1'b0; mActive = 1'b1; mFunc = c; acc = 1'b1;
    end
    expPulse = acc || clrEff;
    #1;
    check(c == 8'o300 ? "R7 clear pulse" : "R2 data channel clear", dataChanClr, expPulse);
    check("R7 abort pulse", engAbort, clrEff);
    @(negedge clk);
    hostWrStb = 1'b0;
    check(acc ? "R2 accept status" : (c == 8'o300 ? "R7 clear status" : "R3 R4 R5 R6 reject status"),
          statusWord, mSt);
    check("R2 R3 R7 flag after write", cmdFlag, mFlag);
  endtask

  task automatic statusRead();
    @(negedge clk); statRdStb = 1'b1;
    @(negedge clk); statRdStb = 1'b0;
    if (driveAttached)
      mSt = (mSt & ~9'o405) | (mActive ? 9'o001 : 9'o000) | (writeProtect ? 9'o004 : 9'o000);
    else
      mSt = 9'o401;
    check("R8 status refresh", statusWord, mSt);
  endtask

  // after an accept: count cycles to start (first negedge already passed)
  task automatic waitStart(input logic [7:0] c);
    int n;
    n = 1;
    while (!engStart && n < 50) begin
      @(negedge clk); n++;
    end
    check("R2 start latency", n, D);
    check("R2 engine function", engFunc, c);
    @(negedge clk);
    check("R2 start single", engStart, 1'b0);
  endtask

  task automatic engineDone(input logic [8:0] res);
    @(negedge clk);
    engDone = 1'b1; engResult = res;
    #1;
    check("R10 offline pulse", goOffline, mFunc == 8'o101);
    @(negedge clk);
    engDone = 1'b0;
    case (mFunc)
      8'o201: begin mSt = (mSt | 9'o100) & ~9'o001; mFlag = 1'b1; end
      8'o101: begin mSt = 9'o401; end
      8'o035: begin mSt = (mSt | 9'o200) & ~9'o001; mFlag = 1'b1; end
      default: begin mSt = (mSt | (res & 9'o362)) & ~9'o001; mFlag = 1'b1; end
    endcase
    mActive = 1'b0;
    check(mFunc == 8'o201 ? "R9 rewind done" : mFunc == 8'o101 ? "R10 rewind-offline done" :
          mFunc == 8'o035 ? "R11 file mark done" : "R12 operation done", statusWord, mSt);
    check("R9 R10 R11 R12 completion flag", cmdFlag, mFlag);
  endtask

  task automatic flagClear();
    @(negedge clk); hostFlagClr = 1'b1;
    @(negedge clk); hostFlagClr = 1'b0;
    mFlag = 1'b0;
    check("R13 host flag clear", cmdFlag, 1'b0);
  endtask

  task automatic reattach();
    driveAttached = 1'b0;
    statusRead();
    driveAttached = 1'b1; tapeAtStart = 1'b1;
    begin logic a; hostWrite(8'o300, a); end
  endtask

  task automatic runOp(input logic [7:0] c, input logic midWrite, input logic [7:0] mid);
    logic acc, a2, aborted;
    aborted = 1'b0;
    hostWrite(c, acc);
    if (!acc) begin
      int n;
      n = 0;
      for (int i = 0; i < D + 2; i++) begin
        @(negedge clk); if (engStart) n++;
      end
      check("R3 no start after reject", n, 0);
      return;
    end
    waitStart(c);
    if (midWrite) begin
      statusRead();
      hostWrite(mid, a2);
      if (mid == 8'o300 && !isRew(c)) aborted = 1'b1;
    end
    if (!aborted) begin
      engineDone(9'($urandom_range(0, 511)));
      if (c == 8'o101) reattach();
    end
  endtask

  localparam logic [7:0] PICK [10] = '{8'o031, 8'o023, 8'o011, 8'o003, 8'o041,
                                       8'o201, 8'o101, 8'o035, 8'o300, 8'o077};

  initial begin
    logic a;
    int seedDummy;
    seedDummy = $urandom(32'd2024);

    // R1: reset with and without a drive
    driveAttached = 1'b1; writeProtect = 1'b0; tapeAtStart = 1'b1;
    doReset();
    driveAttached = 1'b0;
    doReset();
    driveAttached = 1'b1; writeProtect = 1'b1; tapeAtStart = 1'b0;
    doReset();
    writeProtect = 1'b0; tapeAtStart = 1'b1;
    doReset();

    // R4: detached drive rejects a valid code
    driveAttached = 1'b0;
    hostWrite(8'o023, a);
    driveAttached = 1'b1;
    hostWrite(8'o300, a);

    // R5: backward moves rejected at BOT
    runOp(8'o041, 1'b0, 8'd0);
    runOp(8'o201, 1'b0, 8'd0);
    hostWrite(8'o300, a);

    // R6: writes rejected under protection
    writeProtect = 1'b1;
    statusRead();
    runOp(8'o031, 1'b0, 8'd0);
    runOp(8'o011, 1'b0, 8'd0);
    runOp(8'o035, 1'b0, 8'd0);
    writeProtect = 1'b0;
    statusRead();

    // R3: unknown code
    runOp(8'o077, 1'b0, 8'd0);

    // R2 R11 R12: forward, file mark, then backward and rewind
    runOp(8'o003, 1'b0, 8'd0);
    runOp(8'o035, 1'b0, 8'd0);
    flagClear();
    runOp(8'o041, 1'b1, 8'o023);
    runOp(8'o023, 1'b0, 8'd0);
    // R7: clear ignored during rewind, R9 rewind completes
    runOp(8'o201, 1'b1, 8'o300);
    // R7: clear aborts a read
    runOp(8'o023, 1'b1, 8'o300);
    // R10: rewind-offline
    runOp(8'o003, 1'b0, 8'd0);
    runOp(8'o101, 1'b1, 8'o300);

    // random mix
    for (int it = 0; it < 80; it++) begin
      logic [7:0] c, mid;
      int k;
      k = $urandom_range(0, 10);
      c = (k == 10) ? 8'($urandom_range(0, 255)) : PICK[k];
      k = $urandom_range(0, 9);
      mid = (k == 9) ? 8'($urandom_range(0, 255)) : PICK[k];
      if ($urandom_range(0, 3) == 0) begin
        writeProtect = 1'($urandom_range(0, 1));
        statusRead();
      end
      if (c == 8'o300) tapeAtStart = 1'($urandom_range(0, 1));
      runOp(c, 1'($urandom_range(0, 1)), mid);
      if (mFlag && $urandom_range(0, 2) == 0) flagClear();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule